// File: doc/BRIEF.md
# Carry-Save Modulo Adder

This block adds two residues modulo a fixed constant `M` and never propagates a carry across the full word. Each operand arrives as a pair of `N`-bit vectors, a sum vector and a carry vector. The operand's value is the residue of their arithmetic sum modulo `M`, and any split is accepted. The result leaves in the same two-vector form, so a following stage can keep accumulating without a carry-propagate adder. A consumer that needs plain binary adds the two output vectors itself.

Two carry-save rows first merge the four input vectors into one pair. Three fold stages follow. Each fold stage looks at the overflow bits at weight 2^N and selects a fix state: `FIX_NONE`, `FIX_SINGLE` or `FIX_DOUBLE`. `FIX_NONE` passes the pair through unchanged. `FIX_SINGLE` drops the overflow bits and adds the gap G = 2^N − M in one carry-save row. `FIX_DOUBLE` drops them and adds 2·G. The state is chosen anew from the overflow count in every fold stage, with no memory between stages. The only transitions are combinational: count 0 selects `FIX_NONE`, count 1 selects `FIX_SINGLE`, and count 2 selects `FIX_DOUBLE`.

Each of the five steps has its own register stage. A valid bit travels alongside the data, so the block accepts one addition per cycle. Its delay does not depend on `N`.

Top module: `redundant_mod_adder`

## Requirements
- R1: For any `N`-bit input vectors, the output satisfies (r_sum + r_carry) mod M = (a_sum + a_carry + b_sum + b_carry) mod M. This holds when 2^(N−1) < M ≤ 2^N.
- R2: The outputs `r_sum` and `r_carry` are `N` bits each, so r_sum + r_carry < 2^(N+1). No bit at weight 2^N or above is left set in the final internal pair.
- R3: `out_valid` rises exactly 5 clock cycles after the `in_valid` that started the addition, with the matching result on the outputs. Back-to-back inputs give back-to-back results. Cycles without `in_valid` give cycles without `out_valid`.
- R4: After the two merge rows, neither vector of the pair has a bit at weight 2^(N+1) set.
- R5: In the first fold stage, the count of overflow bits at weight 2^N across the two vectors selects the fix state: 0 selects `FIX_NONE`, 1 selects `FIX_SINGLE`, and 2 selects `FIX_DOUBLE`. Each fold stage keeps the pair's residue modulo M.
- R6: In the second and third fold stages the sum vector never carries a bit at weight 2^N. The carry vector's bit at weight 2^N therefore alone selects between `FIX_SINGLE` and `FIX_NONE`.
- R7: While `rst_n` is low, `out_valid`, `r_sum` and `r_carry` are all zero.
- R8: With N = 12 and M = 2050, adding A = 1272 and B = 450 (carry vectors zero) gives a pair whose sum is congruent to 1722.
- R9: With M = 2^N the gap is zero, and the block reduces modulo 2^N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the input vectors as an addition to perform |
| a_sum | input | N | Sum vector of operand A |
| a_carry | input | N | Carry vector of operand A |
| b_sum | input | N | Sum vector of operand B |
| b_carry | input | N | Carry vector of operand B |
| out_valid | output | 1 | Marks the output pair as a finished result |
| r_sum | output | N | Sum vector of the result |
| r_carry | output | N | Carry vector of the result |

## Verification
The bench builds two instances. The first uses N = 12 and M = 2050, just above the lower modulus bound, so the gap of 2046 is large. That drives every fold stage into `FIX_DOUBLE` and `FIX_SINGLE` and exercises the worked vector of R8. The second uses N = 5 and M = 32, where the gap is zero. There all three fold stages run with a zero constant, and the overflow bits are simply dropped.

// File: rtl/modadd_pkg.sv
package modadd_pkg;

    // Correction chosen by one fold stage from the overflow count.
    typedef enum logic [1:0] {
        FIX_NONE   = 2'd0,
        FIX_SINGLE = 2'd1,
        FIX_DOUBLE = 2'd2
    } fix_e;

    // Two merge rows plus three fold stages, one register each.
    localparam int unsigned MERGE_STEPS = 2;
    localparam int unsigned FOLD_STEPS  = 3;
    localparam int unsigned LATENCY     = MERGE_STEPS + FOLD_STEPS;

endpackage

// File: rtl/csa_row.sv
// One carry-save row: three vectors in, a sum/carry pair out.
module csa_row #(
    parameter int W = 14
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] sum,
    output logic [W-1:0] carry
);
    logic [W-2:0] maj;

    assign sum   = x ^ y ^ z;
    assign maj   = (x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) | (y[W-2:0] & z[W-2:0]);
    assign carry = {maj, 1'b0};
endmodule

// File: rtl/fold_stage.sv
// Turns overflow at weight 2^N into a multiple of (2^N - M) and adds it in carry-save form.
module fold_stage
    import modadd_pkg::*;
#(
    parameter int N = 12,
    parameter int M = 2050
) (
    input  logic [N+1:0] s_in,
    input  logic [N+1:0] c_in,
    output logic [N+1:0] s_out,
    output logic [N+1:0] c_out
);
    localparam int W = N + 2;
    localparam int unsigned GAP = (1 << N) - M;
    localparam logic [W-1:0] ADD_ONE = W'(GAP);
    localparam logic [W-1:0] ADD_TWO = W'(2 * GAP);

    logic [1:0]   ovf_cnt;
    fix_e         kind;
    logic [W-1:0] addend;
    logic [W-1:0] lo_s;
    logic [W-1:0] lo_c;
    logic [W-1:0] row_s;
    logic [W-1:0] row_c;

    assign ovf_cnt = {1'b0, s_in[N]} + {1'b0, c_in[N]};
    assign lo_s    = {2'b00, s_in[N-1:0]};
    assign lo_c    = {2'b00, c_in[N-1:0]};

    // Fix state selection.
    always_comb begin
        unique case (ovf_cnt)
            2'd0:    kind = FIX_NONE;
            2'd1:    kind = FIX_SINGLE;
            default: kind = FIX_DOUBLE;
        endcase
    end

    // Correction constant for the chosen state.
    always_comb begin
        unique case (kind)
            FIX_NONE:   addend = '0;
            FIX_SINGLE: addend = ADD_ONE;
            FIX_DOUBLE: addend = ADD_TWO;
            default:    addend = '0;
        endcase
    end

    csa_row #(.W(W)) u_row (
        .x     (lo_s),
        .y     (lo_c),
        .z     (addend),
        .sum   (row_s),
        .carry (row_c)
    );

    // FIX_NONE keeps the pair as it is; the others take the folded row.
    always_comb begin
        if (kind == FIX_NONE) begin
            s_out = s_in;
            c_out = c_in;
        end else begin
            s_out = row_s;
            c_out = row_c;
        end
    end
endmodule

// File: rtl/redundant_mod_adder.sv
module redundant_mod_adder
    import modadd_pkg::*;
#(
    parameter int N = 12,
    parameter int M = 2050
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [N-1:0] a_sum,
    input  logic [N-1:0] a_carry,
    input  logic [N-1:0] b_sum,
    input  logic [N-1:0] b_carry,
    output logic         out_valid,
    output logic [N-1:0] r_sum,
    output logic [N-1:0] r_carry
);
    localparam int W     = N + 2;
    localparam int LAST  = int'(LATENCY);
    localparam int FIRST_FOLD = int'(MERGE_STEPS) + 1;

    // Stage registers: index k holds the pair after step k.
    logic [LAST:1][W-1:0]       st_s;
    logic [LAST:1][W-1:0]       st_c;
    logic [LAST:FIRST_FOLD][W-1:0] fold_s;
    logic [LAST:FIRST_FOLD][W-1:0] fold_c;
    logic [LAST:1]              vld;
    logic [N-1:0]               bc_q;
    logic [2:0]                 warm;

    logic [W-1:0] as_x, ac_x, bs_x, bc_x;
    logic [W-1:0] m1_s, m1_c, m2_s, m2_c;

    assign as_x = {2'b00, a_sum};
    assign ac_x = {2'b00, a_carry};
    assign bs_x = {2'b00, b_sum};
    assign bc_x = {2'b00, bc_q};

    // Merge row 1: A sum, A carry, B sum.
    csa_row #(.W(W)) u_merge1 (
        .x (as_x), .y (ac_x), .z (bs_x), .sum (m1_s), .carry (m1_c)
    );

    // Merge row 2: previous pair and the delayed B carry.
    csa_row #(.W(W)) u_merge2 (
        .x (st_s[1]), .y (st_c[1]), .z (bc_x), .sum (m2_s), .carry (m2_c)
    );

    // Fold stages, one per remaining step.
    for (genvar g = FIRST_FOLD; g <= LAST; g++) begin : g_fold
        fold_stage #(.N(N), .M(M)) u_fold (
            .s_in  (st_s[g-1]),
            .c_in  (st_c[g-1]),
            .s_out (fold_s[g]),
            .c_out (fold_c[g])
        );
    end

    // Pipeline registers for data and valid.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_s <= '0;
            st_c <= '0;
            bc_q <= '0;
            vld  <= '0;
        end else begin
            st_s[1] <= m1_s;
            st_c[1] <= m1_c;
            bc_q    <= b_carry;
            st_s[2] <= m2_s;
            st_c[2] <= m2_c;
            for (int k = FIRST_FOLD; k <= LAST; k++) begin
                st_s[k] <= fold_s[k];
                st_c[k] <= fold_c[k];
            end
            vld <= {vld[LAST-1:1], in_valid};
        end
    end

    // Cycles since reset, saturating, for the latency check.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           warm <= '0;
        else if (warm != 3'd7) warm <= warm + 3'd1;
    end

    assign out_valid = vld[LAST];
    assign r_sum     = st_s[LAST][N-1:0];
    assign r_carry   = st_c[LAST][N-1:0];

    // ---------------- assertions ----------------
    a_r3_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 3'd5) |-> (out_valid == $past(in_valid, 5)));

    a_r7_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && r_sum == '0 && r_carry == '0));

    a_r4_merge_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_s[2][N+1] == 1'b0) && (st_c[2][N+1] == 1'b0));

    a_r2_final_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (st_s[LAST][N+1:N] == 2'b00) && (st_c[LAST][N+1:N] == 2'b00));

    for (genvar g = FIRST_FOLD; g <= LAST; g++) begin : g_chk
        a_r5_fold_keeps_residue: assert property (@(posedge clk) disable iff (!rst_n)
            ((64'(st_s[g]) + 64'(st_c[g])) % 64'(M)) ==
            ((64'($past(st_s[g-1])) + 64'($past(st_c[g-1]))) % 64'(M)));

        a_r6_sum_below_top: assert property (@(posedge clk) disable iff (!rst_n)
            st_s[g][N+1:N] == 2'b00);
    end
endmodule

// File: tb/sim_redundant_mod_adder.sv
module sim_redundant_mod_adder;
    localparam int N0 = 12, M0 = 2050;
    localparam int N1 = 5,  M1 = 32;
    localparam int NT = 8;
    localparam int T_AS [NT] = '{1272, 4095, 0, 2049, 1000, 4095, 2048, 1};
    localparam int T_AC [NT] = '{0,    4095, 0, 0,    1050, 0,    2048, 2};
    localparam int T_BS [NT] = '{450,  4095, 0, 2049, 0,    0,    2048, 3};
    localparam int T_BC [NT] = '{0,    4095, 0, 0,    0,    1,    2048, 4};
    localparam int T_EX [NT] = '{1722, 2030, 0, 2048, 0,    2046, 2042, 10};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          iv0 = 1'b0, ov0;
    logic [N0-1:0] as0 = '0, ac0 = '0, bs0 = '0, bc0 = '0, rs0, rc0;
    logic          iv1 = 1'b0, ov1;
    logic [N1-1:0] as1 = '0, ac1 = '0, bs1 = '0, bc1 = '0, rs1, rc1;

    redundant_mod_adder #(.N(N0), .M(M0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(iv0),
        .a_sum(as0), .a_carry(ac0), .b_sum(bs0), .b_carry(bc0),
        .out_valid(ov0), .r_sum(rs0), .r_carry(rc0));

    redundant_mod_adder #(.N(N1), .M(M1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(iv1),
        .a_sum(as1), .a_carry(ac1), .b_sum(bs1), .b_carry(bc1),
        .out_valid(ov1), .r_sum(rs1), .r_carry(rc1));

    int checks = 0, errors = 0, cyc = 0;
    int exp0 [0:1023]; int pc0 [0:1023]; string tg0 [0:1023]; int wr0 = 0, rd0 = 0;
    int exp1 [0:1023]; int pc1 [0:1023]; string tg1 [0:1023]; int wr1 = 0, rd1 = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Result monitors.
    always @(negedge clk) begin
        if (rst_n && ov0) begin
            check(((int'(rs0) + int'(rc0)) % M0) == exp0[rd0], tg0[rd0],
                  (int'(rs0) + int'(rc0)) % M0, exp0[rd0]);
            check(cyc - pc0[rd0] == 5, "R3 latency u0", cyc - pc0[rd0], 5);
            check(int'(rs0) + int'(rc0) < (1 << (N0 + 1)), "R2 range u0",
                  int'(rs0) + int'(rc0), (1 << (N0 + 1)) - 1);
            rd0++;
        end
        if (rst_n && ov1) begin
            check(((int'(rs1) + int'(rc1)) % M1) == exp1[rd1], tg1[rd1],
                  (int'(rs1) + int'(rc1)) % M1, exp1[rd1]);
            check(cyc - pc1[rd1] == 5, "R3 latency u1", cyc - pc1[rd1], 5);
            rd1++;
        end
    end

    task automatic send0(input int a, input int b, input int c, input int d, input string tag);
        as0 = N0'(a); ac0 = N0'(b); bs0 = N0'(c); bc0 = N0'(d); iv0 = 1'b1;
        exp0[wr0] = (a + b + c + d) % M0; pc0[wr0] = cyc; tg0[wr0] = tag; wr0++;
        @(negedge clk);
        iv0 = 1'b0;
    endtask

    task automatic send1(input int a, input int b, input int c, input int d, input string tag);
        as1 = N1'(a); ac1 = N1'(b); bs1 = N1'(c); bc1 = N1'(d); iv1 = 1'b1;
        exp1[wr1] = (a + b + c + d) % M1; pc1[wr1] = cyc; tg1[wr1] = tag; wr1++;
        @(negedge clk);
        iv1 = 1'b0;
    endtask

    // Random residue x with a random split (s, c) such that (s + c) mod m = x.
    task automatic split(input int n, input int m, output int s, output int c);
        int x;
        x = int'($urandom % m);
        s = int'($urandom % (1 << n));
        c = ((x - s) % m + m) % m;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ov0 == 1'b0, "R7 reset valid", ov0, 0);
        check(rs0 == '0, "R7 reset sum", rs0, 0);
        check(rc0 == '0, "R7 reset carry", rc0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk, back to back.
        for (int i = 0; i < NT; i++) begin
            check(((T_AS[i] + T_AC[i] + T_BS[i] + T_BC[i]) % M0) == T_EX[i],
                  "table self", (T_AS[i] + T_AC[i] + T_BS[i] + T_BC[i]) % M0, T_EX[i]);
            send0(T_AS[i], T_AC[i], T_BS[i], T_BC[i],
                  i == 0 ? "R8 worked vector" :
                  i == 1 ? "R4 R5 all ones double fold" :
                  i == 3 ? "R6 single fold chain" : "R1 table");
        end

        // Random splits with bubbles.
        for (int i = 0; i < 150; i++) begin
            int a_s, a_c, b_s, b_c;
            split(N0, M0, a_s, a_c);
            split(N0, M0, b_s, b_c);
            send0(a_s, a_c, b_s, b_c, "R1 random split");
            if (i % 7 == 3) @(negedge clk);
        end
        // Raw vectors over the full width.
        for (int i = 0; i < 100; i++) begin
            send0(int'($urandom % 4096), int'($urandom % 4096),
                  int'($urandom % 4096), int'($urandom % 4096), "R5 R6 raw vectors");
        end

        // Modulus equal to 2^N.
        send1(31, 31, 31, 31, "R9 all ones m=2^n");
        for (int i = 0; i < 150; i++) begin
            int a_s, a_c, b_s, b_c;
            split(N1, M1, a_s, a_c);
            split(N1, M1, b_s, b_c);
            send1(a_s, a_c, b_s, b_c, "R9 random m=2^n");
        end

        repeat (10) @(negedge clk);
        check(ov0 == 1'b0, "R3 idle no valid u0", ov0, 0);
        check(ov1 == 1'b0, "R3 idle no valid u1", ov1, 0);
        check(rd0 == wr0, "R3 result count u0", rd0, wr0);
        check(rd1 == wr1, "R3 result count u1", rd1, wr1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule